// File: doc/BRIEF.md
# Byte Register File with Pair Writes and Pointer Pairs

This block is the working-register store of a small 8-bit core. It holds thirty-two byte registers and serves two independent byte reads without waiting for a clock. In each clock it accepts one write, which is either a single byte or a 16-bit result. A 16-bit result lands in an aligned pair of registers: the even register takes the low byte and the odd register above it takes the high byte.

A third read path returns any aligned pair as one 16-bit word. The three highest pairs also act as 16-bit address pointers. Their current values are always visible on dedicated outputs. A side port can step one of them up or down by one in the same clock as an ordinary read and write.

Decoding instructions, computing results and producing status flags are left to the surrounding core.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero.
- R2: Both byte read ports are combinational and return the register named by their 5-bit address, where address 0x00 is the first register and 0x1F is the last.
- R3: A byte write (`wr_en`=1, `wr_wide`=0) stores `wr_data[7:0]` into register `wr_addr`. The new value is visible on the read ports from the cycle after the write, and the old value is returned during the write cycle.
- R4: A wide write (`wr_en`=1, `wr_wide`=1) with an even `wr_addr` stores `wr_data[7:0]` in register `wr_addr` and `wr_data[15:8]` in register `wr_addr`+1.
- R5: A wide write with an odd `wr_addr` is ignored, and no register changes.
- R6: The pair read returns `{reg[2p+1], reg[2p]}` for the 4-bit pair index p.
- R7: The pointer outputs are `ptr_x`={reg27,reg26}, `ptr_y`={reg29,reg28} and `ptr_z`={reg31,reg30}.
- R8: `ptr_sel` picks the pointer to update: 2'b00 none, 2'b01 X, 2'b10 Y, 2'b11 Z. With `ptr_dec`=0 the whole 16-bit pair gains one, and with `ptr_dec`=1 it loses one. The carry or borrow crosses between the bytes, and the value wraps modulo 65536.
- R9: If the same cycle's write stores into either register of the selected pointer pair, the pointer step is dropped entirely. The written byte(s) land, and the other byte of the pair keeps its value.
- R10: A pointer step and a write to a register outside that pointer's pair both take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Read port A register address |
| rd_a_data | output | 8 | Read port A data |
| rd_b_addr | input | 5 | Read port B register address |
| rd_b_data | output | 8 | Read port B data |
| pair_idx | input | 4 | Pair read index |
| pair_data | output | 16 | Pair read data, odd register in the high byte |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | 1 selects a 16-bit pair write |
| wr_addr | input | 5 | Write register address (even for wide writes) |
| wr_data | input | 16 | Write data; only bits 7:0 are used by byte writes |
| ptr_sel | input | 2 | Pointer to step: 00 none, 01 X, 10 Y, 11 Z |
| ptr_dec | input | 1 | 0 steps the pointer up, 1 steps it down |
| ptr_x | output | 16 | Pointer X value |
| ptr_y | output | 16 | Pointer Y value |
| ptr_z | output | 16 | Pointer Z value |

## Verification
A faulty write decode shows up on the read ports one cycle after the write. It appears either as the target register missing its new value or as a neighbour that changed when it should not have, and an odd-based wide write is the case most likely to expose a stray store. A wrong pointer step shows up on the pointer outputs in the very next cycle. The carry or borrow across the byte boundary, the wrap at 0xFFFF and a pointer step that collides with a write into its own pair are the cases that separate a correct update from a plausible one.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    PTR_NONE = 2'b00,
    PTR_X    = 2'b01,
    PTR_Y    = 2'b10,
    PTR_Z    = 2'b11
  } ptr_sel_e;

  localparam int unsigned GPR_BYTE_W   = 8;
  localparam int unsigned GPR_COUNT    = 32;
  localparam int unsigned GPR_PTR_NUM  = 3;
  localparam int unsigned GPR_PTR_BASE = 13;

endpackage

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int unsigned N  = 32,
  parameter int unsigned W  = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [SW-1:0]       sel,
  input  logic [N-1:0][W-1:0] din,
  output logic [W-1:0]        dout
);

  assign dout = din[sel];

endmodule

// File: rtl/gpr_wr_dec.sv
module gpr_wr_dec #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  localparam int unsigned AW    = $clog2(NREG),
  localparam int unsigned NPAIR = NREG / 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_wide,
  input  logic [AW-1:0]            wr_addr,
  input  logic [2*DW-1:0]          wr_data,
  output logic [NREG-1:0]          reg_we,
  output logic [NREG-1:0][DW-1:0]  reg_wd,
  output logic [NPAIR-1:0]         pair_hit
);

  logic byte_op, wide_op;
  assign byte_op = wr_en && !wr_wide;
  assign wide_op = wr_en && wr_wide && !wr_addr[0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic byte_hit, wide_hit;
    assign byte_hit  = byte_op && (wr_addr == AW'(i));
    assign wide_hit  = wide_op && (wr_addr[AW-1:1] == (AW-1)'(i / 2));
    assign reg_we[i] = byte_hit || wide_hit;
    if (i % 2 == 1) begin : g_odd
      assign reg_wd[i] = wr_wide ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
    end else begin : g_even
      assign reg_wd[i] = wr_data[DW-1:0];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_hit[p] = reg_we[2*p] || reg_we[2*p+1];
  end

  AST_BYTE_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide) |-> ($countones(reg_we) == 1)); // R3
  AST_WIDE_TWO_TARGETS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && !wr_addr[0]) |-> ($countones(reg_we) == 2)); // R4
  AST_ODD_WIDE_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && wr_addr[0]) |-> (reg_we == '0)); // R5

endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NPTR = 3,
  localparam int unsigned SW  = $clog2(NPTR + 1),
  localparam int unsigned PW  = 2 * DW
) (
  input  logic [SW-1:0]           ptr_sel,
  input  logic                    ptr_dec,
  input  logic [NPTR-1:0][PW-1:0] ptr_vals,
  input  logic [NPTR-1:0]         ptr_hit,
  output logic [NPTR-1:0]         ptr_upd,
  output logic [PW-1:0]           ptr_next
);

  logic [PW-1:0] cur;

  always_comb begin
    cur = '0;
    for (int k = 0; k < NPTR; k++) begin
      if (ptr_sel == SW'(k + 1)) cur = ptr_vals[k];
    end
  end

  assign ptr_next = ptr_dec ? (cur - PW'(1)) : (cur + PW'(1));

  for (genvar k = 0; k < NPTR; k++) begin : g_upd
    assign ptr_upd[k] = (ptr_sel == SW'(k + 1)) && !ptr_hit[k];
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned NREG     = GPR_COUNT,
  parameter int unsigned DW       = GPR_BYTE_W,
  parameter int unsigned NPTR     = GPR_PTR_NUM,
  parameter int unsigned PTR_BASE = GPR_PTR_BASE,
  localparam int unsigned AW    = $clog2(NREG),
  localparam int unsigned NPAIR = NREG / 2,
  localparam int unsigned PIW   = $clog2(NPAIR),
  localparam int unsigned PW    = 2 * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rd_a_addr,
  output logic [DW-1:0]   rd_a_data,
  input  logic [AW-1:0]   rd_b_addr,
  output logic [DW-1:0]   rd_b_data,
  input  logic [PIW-1:0]  pair_idx,
  output logic [PW-1:0]   pair_data,
  input  logic            wr_en,
  input  logic            wr_wide,
  input  logic [AW-1:0]   wr_addr,
  input  logic [PW-1:0]   wr_data,
  input  logic [1:0]      ptr_sel,
  input  logic            ptr_dec,
  output logic [PW-1:0]   ptr_x,
  output logic [PW-1:0]   ptr_y,
  output logic [PW-1:0]   ptr_z
);

  logic [DW-1:0]             regs [NREG];
  logic [NREG-1:0][DW-1:0]   regs_v;
  logic [NPAIR-1:0][PW-1:0]  pairs_v;
  logic [NREG-1:0]           reg_we;
  logic [NREG-1:0][DW-1:0]   reg_wd;
  logic [NPAIR-1:0]          pair_hit;
  logic [NPTR-1:0][PW-1:0]   ptr_vals;
  logic [NPTR-1:0]           ptr_hit;
  logic [NPTR-1:0]           ptr_upd;
  logic [PW-1:0]             ptr_next;
  logic [NPAIR-1:0]          pair_step;

  for (genvar i = 0; i < NREG; i++) begin : g_view
    assign regs_v[i] = regs[i];
  end
  for (genvar p = 0; p < NPAIR; p++) begin : g_pview
    assign pairs_v[p] = {regs[2*p+1], regs[2*p]};
  end

  gpr_wr_dec #(.NREG(NREG), .DW(DW)) u_wr_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_wide  (wr_wide),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .reg_we   (reg_we),
    .reg_wd   (reg_wd),
    .pair_hit (pair_hit)
  );

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign ptr_vals[k] = pairs_v[PTR_BASE + k];
    assign ptr_hit[k]  = pair_hit[PTR_BASE + k];
  end

  gpr_ptr_unit #(.DW(DW), .NPTR(NPTR)) u_ptr (
    .ptr_sel  (ptr_sel),
    .ptr_dec  (ptr_dec),
    .ptr_vals (ptr_vals),
    .ptr_hit  (ptr_hit),
    .ptr_upd  (ptr_upd),
    .ptr_next (ptr_next)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_step
    if (p >= PTR_BASE && p < PTR_BASE + NPTR) begin : g_on
      assign pair_step[p] = ptr_upd[p - PTR_BASE];
    end else begin : g_off
      assign pair_step[p] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (reg_we[i])          regs[i] <= reg_wd[i];
        else if (pair_step[i/2]) regs[i] <= ptr_next[(i%2)*DW +: DW];
      end
    end
  end

  gpr_rd_mux #(.N(NREG), .W(DW)) u_rd_a (
    .sel (rd_a_addr), .din (regs_v), .dout (rd_a_data));
  gpr_rd_mux #(.N(NREG), .W(DW)) u_rd_b (
    .sel (rd_b_addr), .din (regs_v), .dout (rd_b_data));
  gpr_rd_mux #(.N(NPAIR), .W(PW)) u_rd_p (
    .sel (pair_idx), .din (pairs_v), .dout (pair_data));

  assign ptr_x = pairs_v[PTR_BASE];
  assign ptr_y = pairs_v[PTR_BASE + 1];
  assign ptr_z = pairs_v[PTR_BASE + 2];

  AST_BYTE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide) |=> (regs_v[$past(wr_addr)] == $past(wr_data[DW-1:0]))); // R3
  AST_WIDE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && !wr_addr[0]) |=> (pairs_v[$past(wr_addr[AW-1:1])] == $past(wr_data))); // R4
  AST_ODD_WIDE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && wr_addr[0] && ptr_sel == PTR_NONE) |=> $stable(regs_v)); // R5
  AST_PTR_X_STEP: assert property (@(posedge clk) disable iff (rst)
    (ptr_sel == PTR_X && !(wr_en && wr_addr[AW-1:1] == (AW-1)'(PTR_BASE)))
    |=> (ptr_x == ($past(ptr_dec) ? PW'($past(ptr_x) - PW'(1)) : PW'($past(ptr_x) + PW'(1))))); // R8
  AST_PTR_YIELDS: assert property (@(posedge clk) disable iff (rst)
    (ptr_sel == PTR_X && wr_en && !wr_wide && wr_addr == AW'(2 * PTR_BASE))
    |=> (regs_v[2*PTR_BASE+1] == $past(regs_v[2*PTR_BASE+1]))); // R9

endmodule

// File: tb/sim_gpr_file.sv
`timescale 1ns/1ps
module sim_gpr_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [3:0]  pair_idx = '0;
  logic [15:0] pair_data, wr_data = '0, ptr_x, ptr_y, ptr_z;
  logic        wr_en = 1'b0, wr_wide = 1'b0, ptr_dec = 1'b0;
  logic [1:0]  ptr_sel = 2'b00;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [32];

  always #4 clk = ~clk;

  gpr_file u0 (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .pair_idx(pair_idx), .pair_data(pair_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_dec(ptr_dec),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mpair(input int p);
    return {mdl[2*p+1], mdl[2*p]};
  endfunction

  // One clock with the given controls; the model follows the requirements.
  task automatic cyc(input logic we, input logic wide, input logic [4:0] wa,
                     input logic [15:0] wd, input logic [1:0] ps, input logic pd);
    int hitp;
    logic [15:0] nv;
    wr_en = we; wr_wide = wide; wr_addr = wa; wr_data = wd;
    ptr_sel = ps; ptr_dec = pd;
    @(posedge clk);
    hitp = -1;
    if (we && !wide) hitp = int'(wa) / 2;
    if (we && wide && !wa[0]) hitp = int'(wa) / 2;
    if (ps != 2'b00 && hitp != 12 + int'(ps)) begin
      nv = pd ? mpair(12 + int'(ps)) - 16'd1 : mpair(12 + int'(ps)) + 16'd1;
      mdl[2*(12+int'(ps))]   = nv[7:0];
      mdl[2*(12+int'(ps))+1] = nv[15:8];
    end
    if (we && !wide) mdl[wa] = wd[7:0];
    if (we && wide && !wa[0]) begin
      mdl[wa] = wd[7:0];
      mdl[wa + 5'd1] = wd[15:8];
    end
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0; ptr_sel = 2'b00; ptr_dec = 1'b0;
  endtask

  task automatic chk_reg(input string req, input int idx);
    rd_a_addr = 5'(idx); rd_b_addr = 5'(31 - idx);
    #1;
    chk(req, {8'h0, rd_a_data}, {8'h0, mdl[idx]});
    chk(req, {8'h0, rd_b_data}, {8'h0, mdl[31 - idx]});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    for (int i = 0; i < 16; i++) chk_reg("R1 reset clear", i);
  endtask

  task automatic t_byte;
    rd_a_addr = 5'd0; rd_b_addr = 5'd31;
    wr_en = 1'b1; wr_wide = 1'b0; wr_addr = 5'd0; wr_data = 16'h775A;
    #1;
    chk("R3 old value during write", {8'h0, rd_a_data}, 16'h0000);
    cyc(1'b1, 1'b0, 5'd0, 16'h775A, 2'b00, 1'b0);
    cyc(1'b1, 1'b0, 5'd31, 16'h00A5, 2'b00, 1'b0);
    rd_a_addr = 5'h00; rd_b_addr = 5'h1F; #1;
    chk("R2 R3 port A address 0x00", {8'h0, rd_a_data}, 16'h005A);
    chk("R2 R3 port B address 0x1F", {8'h0, rd_b_data}, 16'h00A5);
    chk_reg("R3 neighbour untouched", 1);
  endtask

  task automatic t_wide;
    cyc(1'b1, 1'b1, 5'd4, 16'hBEEF, 2'b00, 1'b0);
    chk_reg("R4 wide low byte", 4);
    chk_reg("R4 wide high byte", 5);
    pair_idx = 4'd2; #1;
    chk("R6 pair read", pair_data, 16'hBEEF);
    chk("R6 pair model", pair_data, mpair(2));
  endtask

  task automatic t_odd;
    cyc(1'b1, 1'b1, 5'd6, 16'h1122, 2'b00, 1'b0);
    cyc(1'b1, 1'b1, 5'd7, 16'h3344, 2'b00, 1'b0);
    pair_idx = 4'd3; #1;
    chk("R5 odd wide ignored pair3", pair_data, 16'h1122);
    pair_idx = 4'd4; #1;
    chk("R5 odd wide ignored pair4", pair_data, 16'h0000);
  endtask

  task automatic t_ptr_view;
    cyc(1'b1, 1'b1, 5'd26, 16'h00FF, 2'b00, 1'b0);
    cyc(1'b1, 1'b1, 5'd28, 16'h0100, 2'b00, 1'b0);
    cyc(1'b1, 1'b1, 5'd30, 16'hFFFF, 2'b00, 1'b0);
    #1;
    chk("R7 ptr_x", ptr_x, 16'h00FF);
    chk("R7 ptr_y", ptr_y, 16'h0100);
    chk("R7 ptr_z", ptr_z, 16'hFFFF);
  endtask

  task automatic t_ptr_step;
    cyc(1'b0, 1'b0, 5'd0, 16'h0, 2'b01, 1'b0); #1;
    chk("R8 X up carry", ptr_x, 16'h0100);
    cyc(1'b0, 1'b0, 5'd0, 16'h0, 2'b10, 1'b1); #1;
    chk("R8 Y down borrow", ptr_y, 16'h00FF);
    cyc(1'b0, 1'b0, 5'd0, 16'h0, 2'b11, 1'b0); #1;
    chk("R8 Z wrap up", ptr_z, 16'h0000);
    cyc(1'b0, 1'b0, 5'd0, 16'h0, 2'b11, 1'b1); #1;
    chk("R8 Z wrap down", ptr_z, 16'hFFFF);
    cyc(1'b0, 1'b0, 5'd0, 16'h0, 2'b00, 1'b1); #1;
    chk("R8 none X", ptr_x, 16'h0100);
    chk("R8 none Y", ptr_y, 16'h00FF);
    chk("R8 none Z", ptr_z, 16'hFFFF);
  endtask

  task automatic t_conflict;
    cyc(1'b1, 1'b0, 5'd27, 16'h0077, 2'b01, 1'b0); #1;
    chk("R9 byte write wins", ptr_x, 16'h7700);
    cyc(1'b1, 1'b1, 5'd30, 16'h1234, 2'b11, 1'b1); #1;
    chk("R9 wide write wins", ptr_z, 16'h1234);
  endtask

  task automatic t_parallel;
    cyc(1'b1, 1'b0, 5'd9, 16'h00C3, 2'b10, 1'b0); #1;
    chk("R10 pointer stepped", ptr_y, 16'h0100);
    chk_reg("R10 write landed", 9);
    cyc(1'b1, 1'b0, 5'd26, 16'h0011, 2'b10, 1'b1); #1;
    chk("R10 other pointer write", ptr_x, 16'h7711);
    chk("R10 Y stepped down", ptr_y, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_byte();
    t_wide();
    t_odd();
    t_ptr_view();
    t_ptr_step();
    t_conflict();
    t_parallel();
    for (int i = 0; i < 16; i++) chk_reg("R2 final sweep", i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule